// File: doc/BRIEF.md
# DS3 Receive Payload Serial Output Stage

This block sits at the receive edge of a DS3 channel and hands the recovered serial bit stream to local terminal equipment. Each recovered bit arrives with a one-cycle valid strobe on the line clock. An internal M-frame position tracker marks every bit as overhead or payload. The block re-times the bit onto a serial data output and produces an output clock strobe. That strobe is a synchronous clock-enable, not a derived clock.

A single configuration bit picks the presentation mode. In continuous mode (`cfg_gap_clk = 0`) every accepted bit is strobed, and an overhead indicator rises alongside each overhead bit. In gapped mode (`cfg_gap_clk = 1`) the strobe is suppressed for overhead bits, so the terminal sees only payload edges. The serial data output still advances over the overhead bits, and the indicator stays low.

Two small state machines drive the behaviour:
- The position sequencer has states `ST_OH` and `ST_PAY`. `ST_OH` means the next accepted bit is the first bit of an 85-bit block. An accepted bit in `ST_OH` moves it to `ST_PAY`. An accepted bit in `ST_PAY` that is the last bit of its block moves it back to `ST_OH`.
- The mode register has states `MODE_CONT` and `MODE_GAP`. It loads the configuration bit every cycle, moving `MODE_CONT`→`MODE_GAP` when the bit is 1 and `MODE_GAP`→`MODE_CONT` when it is 0.

Reset enters `ST_OH` and `MODE_CONT`. The frame is 7 subframes × 8 blocks × 85 bits = 4760 bits.

Top module: `ds3_rx_payload_out`

## Requirements
- R1: While `rst` is high at a rising edge, all three outputs are 0 after that edge. The first bit accepted after reset is at frame position 0.
- R2: A bit is accepted when `rx_bit_vld` is 1. Accepted bits are numbered 0 to 4759 and wrap to 0. The bit at position p is overhead exactly when p mod 85 equals 0, and all others are payload.
- R3: One cycle after an accepted bit, `pay_ser` equals that bit in both modes, overhead bits included.
- R4: In continuous mode, `pay_clk_en` is 1 for one cycle, one cycle after every accepted bit.
- R5: In continuous mode, `oh_ind` is 1 one cycle after an accepted overhead bit and 0 one cycle after an accepted payload bit.
- R6: In gapped mode, `pay_clk_en` is 1 one cycle after an accepted payload bit and 0 one cycle after an accepted overhead bit.
- R7: In gapped mode, `oh_ind` is 0 in every cycle.
- R8: One cycle after a cycle with `rx_bit_vld = 0`, `pay_clk_en` and `oh_ind` are 0 and `pay_ser` keeps its value.
- R9: The mode is registered. A bit accepted in the same cycle as a change of `cfg_gap_clk` is presented in the previous mode, and bits accepted later use the new mode. Mode changes do not disturb the frame position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gap_clk | input | 1 | 1 = gapped payload-only strobe, 0 = continuous strobe with overhead indicator |
| rx_bit_vld | input | 1 | Recovered bit present this cycle |
| rx_bit | input | 1 | Recovered bit value |
| pay_ser | output | 1 | Serial data to terminal equipment |
| pay_clk_en | output | 1 | Output clock strobe, one cycle per presented bit |
| oh_ind | output | 1 | Overhead indicator (continuous mode only) |

## Verification
Two functions can meet in one cycle: a mode change and the presentation of an overhead bit. The bench provokes this by flipping `cfg_gap_clk` in exactly the cycle that carries a block's first bit, once in each direction. It then judges the overhead bit by the old mode's rules and the following payload bits by the new mode's rules. The expected frame position is counted arithmetically across the whole sweep, so any disturbance of the position by the switch also shows up.

// File: rtl/ds3_rxpo_pkg.sv
package ds3_rxpo_pkg;
    // Frame geometry
    localparam int unsigned BLK_BITS_DEF     = 85;
    localparam int unsigned BLKS_PER_SUB_DEF = 8;
    localparam int unsigned SUBS_PER_FRM_DEF = 7;

    // Position sequencer states
    typedef enum logic {
        ST_OH  = 1'b0,
        ST_PAY = 1'b1
    } pos_state_t;

    // Presentation mode states
    typedef enum logic {
        MODE_CONT = 1'b0,
        MODE_GAP  = 1'b1
    } mode_state_t;
endpackage

// File: rtl/ds3_frame_pos.sv
module ds3_frame_pos
    import ds3_rxpo_pkg::*;
#(
    parameter int unsigned BLK_BITS     = BLK_BITS_DEF,
    parameter int unsigned BLKS_PER_SUB = BLKS_PER_SUB_DEF,
    parameter int unsigned SUBS_PER_FRM = SUBS_PER_FRM_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    output logic is_oh_o
);
    localparam int unsigned BW = (BLK_BITS     > 1) ? $clog2(BLK_BITS)     : 1;
    localparam int unsigned KW = (BLKS_PER_SUB > 1) ? $clog2(BLKS_PER_SUB) : 1;
    localparam int unsigned SW = (SUBS_PER_FRM > 1) ? $clog2(SUBS_PER_FRM) : 1;
    localparam logic [BW-1:0] BIT_LAST = BW'(BLK_BITS - 1);
    localparam logic [KW-1:0] BLK_LAST = KW'(BLKS_PER_SUB - 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(SUBS_PER_FRM - 1);

    logic [BW-1:0] bit_q;
    logic [KW-1:0] blk_q;
    logic [SW-1:0] sub_q;
    pos_state_t    st_q, st_d;

    logic bit_wrap, blk_wrap;
    assign bit_wrap = (bit_q == BIT_LAST);
    assign blk_wrap = bit_wrap && (blk_q == BLK_LAST);

    // Bit within block
    always_ff @(posedge clk) begin
        if (rst)
            bit_q <= '0;
        else if (adv_i)
            bit_q <= bit_wrap ? '0 : bit_q + 1'b1;
    end

    // Block within subframe
    always_ff @(posedge clk) begin
        if (rst)
            blk_q <= '0;
        else if (adv_i && bit_wrap)
            blk_q <= (blk_q == BLK_LAST) ? '0 : blk_q + 1'b1;
    end

    // Subframe within M-frame
    always_ff @(posedge clk) begin
        if (rst)
            sub_q <= '0;
        else if (adv_i && blk_wrap)
            sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
    end

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_OH;
        else
            st_q <= st_d;
    end

    // Sequencer next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OH:  if (adv_i) st_d = (BLK_BITS == 1) ? ST_OH : ST_PAY;
            ST_PAY: if (adv_i && bit_wrap) st_d = ST_OH;
        endcase
    end

    // Sequencer output
    always_comb begin
        unique case (st_q)
            ST_OH:  is_oh_o = 1'b1;
            ST_PAY: is_oh_o = 1'b0;
        endcase
    end

    // R2
    st_matches_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OH) == (bit_q == '0));
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_q <= BIT_LAST) && (blk_q <= BLK_LAST) && (sub_q <= SUB_LAST));
    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && blk_wrap && sub_q == SUB_LAST) |=>
            (bit_q == '0 && blk_q == '0 && sub_q == '0));
    // R1
    rst_pos_chk: assert property (@(posedge clk)
        rst |=> (st_q == ST_OH && bit_q == '0));
endmodule

// File: rtl/ds3_pay_out_stage.sv
module ds3_pay_out_stage
    import ds3_rxpo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_gap_i,
    input  logic vld_i,
    input  logic bit_i,
    input  logic is_oh_i,
    output logic ser_o,
    output logic clk_en_o,
    output logic oh_ind_o
);
    mode_state_t mode_q, mode_d;
    logic        clk_en_d, oh_ind_d;

    // Mode next state
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_CONT: if (cfg_gap_i)  mode_d = MODE_GAP;
            MODE_GAP:  if (!cfg_gap_i) mode_d = MODE_CONT;
        endcase
    end

    // Mode state register
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_CONT;
        else
            mode_q <= mode_d;
    end

    // Output decode
    always_comb begin
        unique case (mode_q)
            MODE_CONT: begin
                clk_en_d = vld_i;
                oh_ind_d = vld_i && is_oh_i;
            end
            MODE_GAP: begin
                clk_en_d = vld_i && !is_oh_i;
                oh_ind_d = 1'b0;
            end
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ser_o    <= 1'b0;
            clk_en_o <= 1'b0;
            oh_ind_o <= 1'b0;
        end else begin
            if (vld_i)
                ser_o <= bit_i;
            clk_en_o <= clk_en_d;
            oh_ind_o <= oh_ind_d;
        end
    end

    // R1
    rst_out_chk: assert property (@(posedge clk)
        rst |=> (!ser_o && !clk_en_o && !oh_ind_o));
    // R3
    ser_follow_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> (ser_o == $past(bit_i)));
    // R4
    cont_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && mode_q == MODE_CONT) |=> clk_en_o);
    // R6
    gap_oh_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && is_oh_i && mode_q == MODE_GAP) |=> !clk_en_o);
    // R7
    gap_ind_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_GAP) |=> !oh_ind_o);
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> (!clk_en_o && !oh_ind_o && $stable(ser_o)));
    // R5
    ind_implies_edge_chk: assert property (@(posedge clk) disable iff (rst)
        oh_ind_o |-> clk_en_o);
endmodule

// File: rtl/ds3_rx_payload_out.sv
module ds3_rx_payload_out
    import ds3_rxpo_pkg::*;
#(
    parameter int unsigned BLK_BITS     = BLK_BITS_DEF,
    parameter int unsigned BLKS_PER_SUB = BLKS_PER_SUB_DEF,
    parameter int unsigned SUBS_PER_FRM = SUBS_PER_FRM_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_gap_clk,
    input  logic rx_bit_vld,
    input  logic rx_bit,
    output logic pay_ser,
    output logic pay_clk_en,
    output logic oh_ind
);
    logic bit_is_oh;

    ds3_frame_pos #(
        .BLK_BITS    (BLK_BITS),
        .BLKS_PER_SUB(BLKS_PER_SUB),
        .SUBS_PER_FRM(SUBS_PER_FRM)
    ) u_pos (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (rx_bit_vld),
        .is_oh_o(bit_is_oh)
    );

    ds3_pay_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .cfg_gap_i(cfg_gap_clk),
        .vld_i    (rx_bit_vld),
        .bit_i    (rx_bit),
        .is_oh_i  (bit_is_oh),
        .ser_o    (pay_ser),
        .clk_en_o (pay_clk_en),
        .oh_ind_o (oh_ind)
    );
endmodule

// File: tb/ds3_rx_payload_out_tb.sv
module ds3_rx_payload_out_tb;
    localparam int FRM_BITS = 4760;
    localparam int BLK      = 85;

    logic clk = 1'b0;
    logic rst, cfg, vld, din;
    logic pay_ser, pay_clk_en, oh_ind;

    int   checks   = 0;
    int   failures = 0;
    int   pos;
    logic mode_m;
    logic last_d;
    logic [15:0] lfsr = 16'hACE1;
    bit   done = 0;

    always #10 clk = ~clk;

    ds3_rx_payload_out u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_gap_clk(cfg),
        .rx_bit_vld (vld),
        .rx_bit     (din),
        .pay_ser    (pay_ser),
        .pay_clk_en (pay_clk_en),
        .oh_ind     (oh_ind)
    );

    task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // One cycle: drive at negedge, check at the following negedge
    task automatic cyc(input logic v, input logic b, input logic g, input string ctx);
        logic used_gap, is_oh, e_clk, e_ind, e_dat;
        string tc, ti;
        vld = v; din = b; cfg = g;
        used_gap = mode_m;
        is_oh = (pos % BLK == 0);
        @(posedge clk);
        @(negedge clk);
        mode_m = g;
        if (v) begin
            e_dat = b;
            e_clk = used_gap ? !is_oh : 1'b1;
            e_ind = !used_gap && is_oh;
            tc = used_gap ? "R6" : "R4";
            ti = used_gap ? "R7" : "R5";
            if (is_oh) begin tc = {tc, "/R2"}; ti = {ti, "/R2"}; end
            chk(pay_ser == e_dat, {ctx, "R3 data"}, pay_ser, e_dat);
            pos = (pos + 1) % FRM_BITS;
            last_d = b;
        end else begin
            e_dat = last_d; e_clk = 1'b0; e_ind = 1'b0;
            tc = "R8"; ti = "R8";
            chk(pay_ser == e_dat, {ctx, "R8 hold"}, pay_ser, e_dat);
        end
        chk(pay_clk_en == e_clk, {ctx, tc, " strobe"}, pay_clk_en, e_clk);
        chk(oh_ind == e_ind, {ctx, ti, " indicator"}, oh_ind, e_ind);
    endtask

    task automatic do_reset();
        vld = 0; din = 0; cfg = 0; rst = 1;
        repeat (2) @(negedge clk);
        chk(pay_ser == 1'b0,    "R1 reset data",      pay_ser,    1'b0);
        chk(pay_clk_en == 1'b0, "R1 reset strobe",    pay_clk_en, 1'b0);
        chk(oh_ind == 1'b0,     "R1 reset indicator", oh_ind,     1'b0);
        rst = 0; pos = 0; mode_m = 0; last_d = 0;
    endtask

    // Sweep slightly over a frame with idle gaps
    task automatic sweep(input logic g, input int nbits, input string ctx);
        int n = 0;
        int i = 0;
        while (n < nbits) begin
            if (i % 7 == 3) cyc(1'b0, 1'b0, g, ctx);
            else begin cyc(1'b1, next_bit(), g, ctx); n++; end
            i++;
        end
    endtask

    initial begin
        rst = 1; vld = 0; din = 0; cfg = 0;
        @(negedge clk);
        do_reset();
        // R1: first accepted bit after reset is overhead
        cyc(1'b1, 1'b1, 1'b0, "R1 first-bit ");
        sweep(1'b0, FRM_BITS + 200, "");
        sweep(1'b1, FRM_BITS + 200, "");
        // R9: switch gap->continuous on an overhead bit
        while (pos % BLK != 0) cyc(1'b1, next_bit(), 1'b1, "");
        cyc(1'b1, 1'b1, 1'b0, "R9 switch-on-oh ");
        repeat (BLK + 3) cyc(1'b1, next_bit(), 1'b0, "R9 after ");
        // R9: switch continuous->gap on an overhead bit
        while (pos % BLK != 0) cyc(1'b1, next_bit(), 1'b0, "");
        cyc(1'b1, 1'b1, 1'b1, "R9 switch-on-oh ");
        repeat (BLK + 3) cyc(1'b1, next_bit(), 1'b1, "R9 after ");
        // R1: reset mid-frame restarts position
        cyc(1'b1, 1'b1, 1'b0, "");
        do_reset();
        cyc(1'b1, 1'b1, 1'b1, "R1 restart ");
        repeat (BLK + 2) cyc(1'b1, next_bit(), 1'b0, "R1 restart ");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule